// File: doc/BRIEF.md
# LIN Bus Receive and Wake Filter

This block sits between the digitized output of the bus comparator and the logic of a LIN node. It brings the asynchronous bus level into the clock domain with a two-flop synchronizer. Two independent filters then work on the synchronized level.

The first filter is a short debounce filter for data. It produces the received data line and drops bus excursions shorter than the debounce time. The second filter is a long wake filter. While the node sleeps, it recognises a remote wake pulse of either polarity. The block also gates the transmit data into a driver command, so the bus stays recessive whenever the mode controller withdraws transmit permission. That happens in sleep, in thermal shutdown and while the output supply is below the master-reset level.

All three enables come from the mode controller. Both filter durations are parameters counted in clock cycles. Their defaults correspond to about 2.8 us and 60 us at 250 MHz. Level encoding on the comparator input and on the data output is 0 for dominant and 1 for recessive.

Top module: `lin_rx_wake_filter`

## Requirements
- R1: After reset, rxd_o is 1 (recessive), drv_dom_o is 0 and wake_req_o is 0.
- R2: With rx_en_i high, a level applied on bus_cmp_i and held for at least DEB_CYC clock edges appears on rxd_o exactly DEB_CYC+2 edges after the first edge that samples it. The data output uses 0 for dominant and 1 for recessive.
- R3: With rx_en_i high, a bus excursion held for fewer than DEB_CYC edges leaves rxd_o unchanged.
- R4: While rx_en_i is low, rxd_o is 1 from the next edge on, and any partial debounce count is discarded.
- R5: While wake_en_i is high, the block latches the bus level on the first edge after enabling as its reference. When the synchronized bus then differs from that reference for WAKE_CYC consecutive edges, wake_req_o pulses high for exactly one cycle. This works for a dominant pulse and for a recessive pulse alike.
- R6: If the bus returns to the reference level before WAKE_CYC edges have passed, the wake count restarts from zero, and pulses that are each shorter than WAKE_CYC raise no request.
- R7: Only one wake request is issued per enable period, however long the bus stays away from the reference. A new request needs wake_en_i to go low and then high again.
- R8: drv_dom_o is registered. One edge after tx_en_i=1 with txd_i=0 it is 1 (dominant). In every other case it is 0 (recessive) one edge later.
- R9: While wake_en_i is low, wake_req_o stays 0 whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_cmp_i | input | 1 | Asynchronous comparator output, 0 dominant, 1 recessive |
| txd_i | input | 1 | Transmit data from the protocol controller, 0 requests dominant |
| tx_en_i | input | 1 | Transmit permission from the mode controller |
| rx_en_i | input | 1 | Receive path enable from the mode controller |
| wake_en_i | input | 1 | Wake detection enable from the mode controller |
| rxd_o | output | 1 | Debounced receive data |
| drv_dom_o | output | 1 | Command to the bus driver, 1 drives dominant |
| wake_req_o | output | 1 | One-cycle remote wake request |

## Verification
The in-RTL assertions check these properties on every cycle:
- the debounce and wake counters stay within range;
- the data output holds while a partial count runs, and idles recessive when the receive path is off;
- the wake request lasts a single cycle and never appears while detection is disabled or already used;
- the driver command stays recessive without transmit permission or with recessive transmit data.

Only the bench scenarios can show behaviour that depends on pulse length and exact latency. This covers:
- the sweep of pulse widths around both thresholds, in both polarities;
- the restart of the wake count after a short return to the reference level;
- re-arming after detection is toggled off and on.

// File: rtl/lrw_pkg.sv
package lrw_pkg;
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;
endpackage

// File: rtl/lrw_sync2.sv
module lrw_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  import lrw_pkg::*;
  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {LVL_REC, LVL_REC};
    else         stg_q <= {stg_q[0], async_i};
  end

  assign sync_o = stg_q[1];
endmodule

// File: rtl/lrw_glitch_filter.sv
module lrw_glitch_filter #(
  parameter int unsigned DEB_CYC = 700
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  output logic lvl_o
);
  import lrw_pkg::*;
  localparam int unsigned CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic          lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      lvl_d = LVL_REC;
      cnt_d = '0;
    end else if (lvl_i == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      lvl_d = lvl_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= LVL_REC;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_o = lvl_q;

  AST_DEB_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R3
  AST_DEB_HOLD_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && lvl_i != lvl_q && cnt_q != LAST) |=> $stable(lvl_q)); // R3
  AST_RXD_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (lvl_q == LVL_REC && cnt_q == '0)); // R4
endmodule

// File: rtl/lrw_wake_det.sv
module lrw_wake_det #(
  parameter int unsigned WAKE_CYC = 15000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  output logic req_o
);
  import lrw_pkg::*;
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  logic          arm_q, arm_d;
  logic          done_q, done_d;
  logic          ref_q, ref_d;
  logic          req_q, req_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    arm_d  = arm_q;
    done_d = done_q;
    ref_d  = ref_q;
    cnt_d  = cnt_q;
    req_d  = 1'b0;
    if (!en_i) begin
      arm_d  = 1'b0;
      done_d = 1'b0;
      cnt_d  = '0;
    end else if (!arm_q) begin
      arm_d = 1'b1;
      ref_d = lvl_i;
      cnt_d = '0;
    end else if (!done_q) begin
      if (lvl_i == ref_q) begin
        cnt_d = '0;
      end else if (cnt_q == LAST) begin
        req_d  = 1'b1;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      done_q <= 1'b0;
      ref_q  <= LVL_REC;
      req_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      arm_q  <= arm_d;
      done_q <= done_d;
      ref_q  <= ref_d;
      req_q  <= req_d;
      cnt_q  <= cnt_d;
    end
  end

  assign req_o = req_q;

  AST_WAKE_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q); // R7
  AST_WAKE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && en_i) |=> !req_q); // R7
  AST_WAKE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_q); // R9
endmodule

// File: rtl/lin_rx_wake_filter.sv
module lin_rx_wake_filter #(
  parameter int unsigned DEB_CYC  = 700,
  parameter int unsigned WAKE_CYC = 15000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_cmp_i,
  input  logic txd_i,
  input  logic tx_en_i,
  input  logic rx_en_i,
  input  logic wake_en_i,
  output logic rxd_o,
  output logic drv_dom_o,
  output logic wake_req_o
);
  import lrw_pkg::*;

  logic bus_s;
  logic drv_q, drv_d;

  lrw_sync2 u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(bus_cmp_i),
    .sync_o (bus_s)
  );

  lrw_glitch_filter #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rx_en_i),
    .lvl_i (bus_s),
    .lvl_o (rxd_o)
  );

  lrw_wake_det #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (wake_en_i),
    .lvl_i (bus_s),
    .req_o (wake_req_o)
  );

  always_comb begin
    drv_d = tx_en_i && (txd_i == LVL_DOM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b0;
    else         drv_q <= drv_d;
  end

  assign drv_dom_o = drv_q;

  AST_DRV_NO_PERMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !drv_dom_o); // R8
  AST_DRV_TXD_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_i |=> !drv_dom_o); // R8
endmodule

// File: tb/lin_rx_wake_filter_tb_top.sv
module lin_rx_wake_filter_tb_top;
  localparam int DEB  = 4;
  localparam int WAKE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus = 1'b1;
  logic txd = 1'b1;
  logic tx_en = 1'b0;
  logic rx_en = 1'b1;
  logic wake_en = 1'b0;
  logic rxd, drv, wreq;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lin_rx_wake_filter #(.DEB_CYC(DEB), .WAKE_CYC(WAKE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_cmp_i(bus), .txd_i(txd),
    .tx_en_i(tx_en), .rx_en_i(rx_en), .wake_en_i(wake_en),
    .rxd_o(rxd), .drv_dom_o(drv), .wake_req_o(wreq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle(input logic lvl, input int n);
    bus = lvl;
    repeat (n) @(negedge clk);
  endtask

  // pulse of opposite level for len cycles; record rxd first-change index and width
  task automatic deb_pulse(input logic base, input int len);
    int first = -1;
    int width = 0;
    settle(base, DEB + 6);
    bus = ~base;
    for (int j = 0; j < len + 2 * DEB + 12; j++) begin
      @(negedge clk);
      if (rxd != base) begin
        width++;
        if (first < 0) first = j;
      end
      if (j == len - 1) bus = base;
    end
    if (len < DEB) begin
      chk(width == 0, "R3 short pulse suppressed", width, 0);
    end else begin
      chk(first == DEB + 1, "R2 debounce latency", first, DEB + 1);
      chk(width == len, "R2 debounced width", width, len);
    end
  endtask

  task automatic arm(input logic ref_lvl);
    wake_en = 1'b0;
    settle(ref_lvl, 6);
    wake_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wake_pulse(input int len, output int cnt, output int first);
    logic base;
    base = bus;
    cnt = 0;
    first = -1;
    bus = ~base;
    for (int j = 0; j < len + WAKE + 10; j++) begin
      @(negedge clk);
      if (wreq) begin
        cnt++;
        if (first < 0) first = j;
      end
      if (j == len - 1) bus = base;
    end
  endtask

  initial begin
    int c, f;
    repeat (3) @(negedge clk);
    chk(rxd == 1'b1, "R1 rxd reset", rxd, 1);
    chk(drv == 1'b0, "R1 drv reset", drv, 0);
    chk(wreq == 1'b0, "R1 wake reset", wreq, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int len = 1; len <= DEB + 3; len++) begin
      deb_pulse(1'b1, len);
      deb_pulse(1'b0, len);
    end

    // R4: receive path off forces recessive
    settle(1'b0, DEB + 8);
    chk(rxd == 1'b0, "R2 dominant settled", rxd, 0);
    rx_en = 1'b0;
    @(negedge clk);
    chk(rxd == 1'b1, "R4 rxd idle when off", rxd, 1);
    repeat (5) @(negedge clk);
    chk(rxd == 1'b1, "R4 rxd stays idle", rxd, 1);
    rx_en = 1'b1;
    repeat (DEB + 2) @(negedge clk);
    chk(rxd == 1'b0, "R4 full debounce after re-enable", rxd, 0);
    settle(1'b1, DEB + 6);

    // R8: transmit gating, all combinations
    for (int k = 0; k < 4; k++) begin
      tx_en = k[1];
      txd = k[0];
      @(negedge clk);
      chk(drv == (k[1] && !k[0]), "R8 driver command", drv, int'(k[1] && !k[0]));
    end
    tx_en = 1'b0;
    txd = 1'b1;

    // R9: no wake while disabled
    wake_en = 1'b0;
    settle(1'b1, 4);
    wake_pulse(3 * WAKE, c, f);
    chk(c == 0, "R9 no wake when disabled", c, 0);

    // R5: width sweep, both polarities
    for (int len = WAKE - 2; len <= WAKE + 2; len++) begin
      arm(1'b1);
      wake_pulse(len, c, f);
      chk(c == (len >= WAKE ? 1 : 0), "R5 dominant wake count", c, (len >= WAKE ? 1 : 0));
      if (len >= WAKE) chk(f == WAKE + 1, "R5 wake latency", f, WAKE + 1);
      arm(1'b0);
      wake_pulse(len, c, f);
      chk(c == (len >= WAKE ? 1 : 0), "R5 recessive wake count", c, (len >= WAKE ? 1 : 0));
    end

    // R6: interrupted pulse restarts the count
    arm(1'b1);
    c = 0;
    bus = 1'b0;
    for (int j = 0; j < 3 * WAKE; j++) begin
      @(negedge clk);
      if (wreq) c++;
      if (j == WAKE - 3) bus = 1'b1;
      if (j == WAKE - 2) bus = 1'b0;
      if (j == 2 * WAKE - 4) bus = 1'b1;
    end
    chk(c == 0, "R6 restart on return", c, 0);

    // R7: one request per enable, re-arm gives another
    arm(1'b1);
    wake_pulse(4 * WAKE, c, f);
    chk(c == 1, "R7 single request", c, 1);
    repeat (4) @(negedge clk);
    wake_pulse(2 * WAKE, c, f);
    chk(c == 0, "R7 no repeat without re-arm", c, 0);
    arm(1'b1);
    wake_pulse(2 * WAKE, c, f);
    chk(c == 1, "R7 request after re-arm", c, 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule